// File: doc/BRIEF.md
# Ring Symbol Abort Detector

This block sits in a ring node between the receive side facing upstream and the transmit side facing downstream. It takes one symbol per clock. Each symbol is a data word with a separate check field. Every symbol received is tested in three ways. The check field must agree with a code regenerated from the data. A header must name an address below the programmed node count. The symbol kinds must arrive in a legal packet order.

Every received symbol is passed downstream one cycle later, including the one that broke a rule. The outgoing check field is always rebuilt from the outgoing data. When the first violation is found, the block raises a sticky abort output. It records why the abort happened, and the syndrome, in a diagnostic capture. It then places one abort symbol into the first idle transmit slot. Later violations change nothing until a synchronous ring reset clears the node.

Top module: `ras_abort_detector`

## Requirements
- R1: A valid symbol whose syndrome (received check field XOR the check field regenerated from its data) is nonzero raises `abort_o` on the next clock edge. It records cause 1 and that syndrome. The check field uses 7 bits. Bits 5:0 are the XOR of the position codes of the set data bits, where data bit j takes the (j+1)-th integer from 3 upward that is not a power of two. Bit 6 is the XOR of all data bits and of bits 5:0.
- R2: A header symbol whose address field (data bits 32:27) is greater than or equal to `node_count` raises an abort with cause 2 and syndrome 0. Lower addresses are legal. The address field of any kind other than header is ignored.
- R3: The symbol kind sits in data bits 34:33: 00 control, 01 header, 10 data, 11 terminator. A header is legal only outside a packet. Data and terminator symbols are legal only inside a packet. A terminator closes the packet. Control symbols are legal anywhere. An illegal kind raises an abort with cause 3 and leaves the packet state unchanged.
- R4: Once raised, `abort_o` stays high until a ring reset, through idle cycles and further symbols.
- R5: Only the first abort is recorded. If one symbol has several faults, the cause recorded is EDC over address over sequence. Later faults leave `diag_cause` and `diag_syndrome` unchanged.
- R6: Every valid received symbol appears on `tx_data` with `tx_valid` high one cycle later, unchanged. This includes the symbol that caused the abort.
- R7: Whenever `tx_valid` is high, `tx_cb` is the correct check field for `tx_data`, even if the received check field was corrupt.
- R8: After the first abort, the block sends one abort symbol in the first cycle that has no valid received symbol. The abort symbol is kind 00 with all other data bits set. It is sent only once per abort.
- R9: `ring_reset` clears the abort, the diagnostics, any pending abort symbol and the packet state, and sends nothing in its cycle. After it, a data symbol is again illegal.
- R10: After chip reset, `abort_o`, `diag_valid` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| ring_reset | input | 1 | Synchronous ring reset |
| node_count | input | ADDR_W+1 | Number of nodes; legal header addresses are below it |
| rx_valid | input | 1 | Received symbol present |
| rx_data | input | DATA_W | Received data word |
| rx_cb | input | 7 | Received check field |
| tx_valid | output | 1 | Transmitted symbol present |
| tx_data | output | DATA_W | Transmitted data word |
| tx_cb | output | 7 | Regenerated check field |
| abort_o | output | 1 | Sticky abort indication |
| diag_valid | output | 1 | Diagnostic capture holds an abort |
| diag_cause | output | 2 | 1 EDC, 2 address, 3 sequence |
| diag_syndrome | output | 7 | Syndrome of the first abort (0 for non-EDC causes) |

## Verification
The assertions take for granted that `node_count` stays steady and is at least one. They also take for granted that `ring_reset` is a single-cycle pulse during which received symbols may be dropped. The bench programs `node_count` once before any symbol is sent. It raises `ring_reset` only with `rx_valid` low. It places idle cycles deliberately so that abort-symbol insertion can be seen in a known slot.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int CB_W = 7;

  typedef enum logic [1:0] {K_CTRL = 2'b00, K_HEAD = 2'b01, K_DATA = 2'b10, K_TERM = 2'b11} kind_e;
  typedef enum logic [1:0] {C_NONE = 2'd0, C_EDC = 2'd1, C_ADDR = 2'd2, C_SEQ = 2'd3} cause_e;
  typedef enum logic {S_WAIT_HEAD = 1'b0, S_IN_PKT = 1'b1} seq_e;

  // Check field: low six bits XOR non-power-of-two position codes, top bit overall parity.
  function automatic logic [CB_W-1:0] edc_gen(input logic [63:0] d, input int n);
    logic [5:0] h;
    logic       par;
    int         pos;
    h   = '0;
    par = 1'b0;
    pos = 2;
    for (int j = 0; j < 64; j++) begin
      if (j < n) begin
        pos++;
        if ((pos & (pos - 1)) == 0) pos++;
        if (d[j]) h = h ^ pos[5:0];
        par = par ^ d[j];
      end
    end
    return {par ^ (^h), h};
  endfunction
endpackage

// File: rtl/ras_edc_check.sv
module ras_edc_check import ras_pkg::*; #(
  parameter int DATA_W = 35
) (
  input  logic              sym_valid,
  input  logic [DATA_W-1:0] data,
  input  logic [CB_W-1:0]   cb,
  output logic [CB_W-1:0]   syndrome,
  output logic              edc_fault
);
  localparam int PAD_W = 64 - DATA_W;

  always_comb begin
    syndrome  = cb ^ edc_gen({{PAD_W{1'b0}}, data}, DATA_W);
    edc_fault = sym_valid && (syndrome != '0);
  end
endmodule

// File: rtl/ras_seq_fsm.sv
module ras_seq_fsm import ras_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ring_reset,
  input  logic  sym_valid,
  input  kind_e kind,
  output logic  seq_fault
);
  seq_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    seq_fault = 1'b0;
    if (sym_valid) begin
      unique case (kind)
        K_CTRL: ;
        K_HEAD: if (st_q == S_IN_PKT) seq_fault = 1'b1; else st_d = S_IN_PKT;
        K_DATA: if (st_q == S_WAIT_HEAD) seq_fault = 1'b1;
        K_TERM: if (st_q == S_WAIT_HEAD) seq_fault = 1'b1; else st_d = S_WAIT_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st_q <= S_WAIT_HEAD;
    else if (ring_reset) st_q <= S_WAIT_HEAD;
    else                 st_q <= st_d;
  end
endmodule

// File: rtl/ras_diag_capture.sv
module ras_diag_capture import ras_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ring_reset,
  input  logic            fault_any,
  input  cause_e          cause,
  input  logic [CB_W-1:0] syndrome,
  input  logic            slot_free,
  output logic            abort_q,
  output logic            diag_valid,
  output cause_e          diag_cause,
  output logic [CB_W-1:0] diag_syndrome,
  output logic            inject
);
  logic pend_q;

  assign inject = pend_q && slot_free && !ring_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q       <= 1'b0;
      diag_valid    <= 1'b0;
      diag_cause    <= C_NONE;
      diag_syndrome <= '0;
      pend_q        <= 1'b0;
    end else if (ring_reset) begin
      abort_q       <= 1'b0;
      diag_valid    <= 1'b0;
      diag_cause    <= C_NONE;
      diag_syndrome <= '0;
      pend_q        <= 1'b0;
    end else if (fault_any && !abort_q) begin
      abort_q       <= 1'b1;
      diag_valid    <= 1'b1;
      diag_cause    <= cause;
      diag_syndrome <= syndrome;
      pend_q        <= 1'b1;
    end else if (inject) begin
      pend_q        <= 1'b0;
    end
  end
endmodule

// File: rtl/ras_abort_detector.sv
module ras_abort_detector import ras_pkg::*; #(
  parameter int DATA_W = 35,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_reset,
  input  logic [ADDR_W:0]   node_count,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CB_W-1:0]   rx_cb,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [CB_W-1:0]   tx_cb,
  output logic              abort_o,
  output logic              diag_valid,
  output logic [1:0]        diag_cause,
  output logic [CB_W-1:0]   diag_syndrome
);
  localparam int KIND_LSB = DATA_W - 2;
  localparam int ADDR_LSB = KIND_LSB - ADDR_W;
  localparam int PAD_W    = 64 - DATA_W;
  localparam logic [DATA_W-1:0] ABORT_SYM = {2'b00, {(DATA_W-2){1'b1}}};

  kind_e           rx_kind;
  logic [ADDR_W-1:0] rx_addr;
  logic [CB_W-1:0] syndrome;
  logic            edc_fault, addr_fault, seq_fault, fault_any, inject;
  cause_e          cause, diag_cause_e;
  logic [CB_W-1:0] cap_syn;
  logic [DATA_W-1:0] tx_next;

  assign rx_kind    = kind_e'(rx_data[KIND_LSB +: 2]);
  assign rx_addr    = rx_data[ADDR_LSB +: ADDR_W];
  assign addr_fault = rx_valid && (rx_kind == K_HEAD) && ({1'b0, rx_addr} >= node_count);
  assign fault_any  = edc_fault || addr_fault || seq_fault;
  assign cause      = edc_fault ? C_EDC : (addr_fault ? C_ADDR : C_SEQ);
  assign cap_syn    = edc_fault ? syndrome : '0;
  assign tx_next    = rx_valid ? rx_data : ABORT_SYM;
  assign diag_cause = diag_cause_e;

  ras_edc_check #(.DATA_W(DATA_W)) u_edc (
    .sym_valid(rx_valid), .data(rx_data), .cb(rx_cb),
    .syndrome(syndrome), .edc_fault(edc_fault)
  );

  ras_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .ring_reset(ring_reset),
    .sym_valid(rx_valid), .kind(rx_kind), .seq_fault(seq_fault)
  );

  ras_diag_capture u_diag (
    .clk(clk), .rst_n(rst_n), .ring_reset(ring_reset),
    .fault_any(fault_any), .cause(cause), .syndrome(cap_syn),
    .slot_free(!rx_valid), .abort_q(abort_o), .diag_valid(diag_valid),
    .diag_cause(diag_cause_e), .diag_syndrome(diag_syndrome), .inject(inject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_cb    <= '0;
    end else if (ring_reset) begin
      tx_valid <= 1'b0;
    end else if (rx_valid || inject) begin
      tx_valid <= 1'b1;
      tx_data  <= tx_next;
      tx_cb    <= edc_gen({{PAD_W{1'b0}}, tx_next}, DATA_W);
    end else begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ras_abort_detector_chk.sv
module ras_abort_detector_chk import ras_pkg::*; #(
  parameter int DATA_W = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ring_reset,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              edc_fault,
  input logic              fault_any,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic [CB_W-1:0]   tx_cb,
  input logic              abort_o,
  input logic              diag_valid,
  input logic [1:0]        diag_cause,
  input logic [CB_W-1:0]   diag_syndrome
);
  localparam int PAD_W = 64 - DATA_W;

  AST_EDC_RAISES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (edc_fault && !ring_reset) |=> abort_o); // R1
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && !ring_reset) |=> abort_o); // R4
  AST_ANY_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !ring_reset) |=> (abort_o && diag_valid)); // R3
  AST_DIAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_valid && !ring_reset) |=> ($stable(diag_cause) && $stable(diag_syndrome))); // R5
  AST_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ring_reset) |=> (tx_valid && tx_data == $past(rx_data))); // R6
  AST_FRESH_CB: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_cb == edc_gen({{PAD_W{1'b0}}, tx_data}, DATA_W))); // R7
  AST_RING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ring_reset |=> (!abort_o && !diag_valid && !tx_valid)); // R9
endmodule

bind ras_abort_detector ras_abort_detector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_reset(ring_reset), .rx_valid(rx_valid),
  .rx_data(rx_data), .edc_fault(edc_fault), .fault_any(fault_any),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_cb(tx_cb), .abort_o(abort_o),
  .diag_valid(diag_valid), .diag_cause(diag_cause), .diag_syndrome(diag_syndrome)
);

// File: tb/ras_abort_detector_test.sv
`timescale 1ns/1ps
module ras_abort_detector_test;
  localparam int DW = 35;
  localparam int AW = 6;
  localparam int NODES = 8;

  logic clk = 1'b0, rst_n = 1'b0, ring_reset = 1'b0, rx_valid = 1'b0;
  logic [AW:0] node_count = NODES;
  logic [DW-1:0] rx_data = '0;
  logic [6:0] rx_cb = '0;
  logic tx_valid, abort_o, diag_valid;
  logic [DW-1:0] tx_data;
  logic [6:0] tx_cb, diag_syndrome;
  logic [1:0] diag_cause;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [5:0] cols [DW];

  always #5 clk = ~clk;

  ras_abort_detector #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_reset(ring_reset), .node_count(node_count),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cb(rx_cb),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_cb(tx_cb), .abort_o(abort_o),
    .diag_valid(diag_valid), .diag_cause(diag_cause), .diag_syndrome(diag_syndrome)
  );

  function automatic logic [6:0] bgen(input logic [DW-1:0] d);
    logic [5:0] h = '0;
    for (int j = 0; j < DW; j++) if (d[j]) h ^= cols[j];
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [DW-1:0] mk(input logic [1:0] k, input int a, input int p);
    return {k, a[AW-1:0], p[DW-AW-3:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one symbol, advance one cycle, leave inputs idle
  task automatic send(input logic [DW-1:0] d, input logic [6:0] flip);
    rx_valid = 1'b1; rx_data = d; rx_cb = bgen(d) ^ flip;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_fwd(input string req, input logic [DW-1:0] d);
    send(d, '0);
    chk({req, " fwd valid"}, tx_valid, 1);
    chk({req, " fwd data"}, tx_data, d);
    chk({req, " fwd cb"}, tx_cb, bgen(d));
  endtask

  task automatic idle();
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rreset();
    ring_reset = 1'b1; rx_valid = 1'b0;
    @(negedge clk);
    ring_reset = 1'b0;
    chk("R9 abort cleared", abort_o, 0);
    chk("R9 diag cleared", diag_valid, 0);
    chk("R9 nothing sent", tx_valid, 0);
  endtask

  task automatic t_reset_state();
    chk("R10 abort", abort_o, 0);
    chk("R10 diag", diag_valid, 0);
    chk("R10 tx", tx_valid, 0);
  endtask

  task automatic t_legal();
    rreset();
    send_fwd("R3 legal head", mk(2'b01, 7, 5));
    send_fwd("R2 data addr ignored", mk(2'b10, 63, 9));
    send_fwd("R3 ctrl in pkt", mk(2'b00, 0, 3));
    send_fwd("R3 term", mk(2'b11, 0, 1));
    send_fwd("R3 head again", mk(2'b01, 0, 2));
    send_fwd("R3 term again", mk(2'b11, 0, 0));
    chk("R3 no abort on legal order", abort_o, 0);
  endtask

  task automatic t_edc();
    logic [DW-1:0] good, bad;
    rreset();
    good = mk(2'b01, 2, 'h1234);
    bad  = good ^ (35'd1 << 5);
    rx_valid = 1'b1; rx_data = bad; rx_cb = bgen(good);
    @(negedge clk); rx_valid = 1'b0;
    chk("R1 abort", abort_o, 1);
    chk("R1 cause", diag_cause, 1);
    chk("R1 syndrome", diag_syndrome, bgen(good) ^ bgen(bad));
    chk("R6 offender forwarded", tx_data, bad);
    chk("R7 fresh cb", tx_cb, bgen(bad));
    idle();
    chk("R8 abort symbol valid", tx_valid, 1);
    chk("R8 abort symbol data", tx_data, {2'b00, {(DW-2){1'b1}}});
    chk("R8 abort symbol cb", tx_cb, bgen({2'b00, {(DW-2){1'b1}}}));
    idle();
    chk("R8 sent only once", tx_valid, 0);
    chk("R4 abort held", abort_o, 1);
  endtask

  task automatic t_double();
    logic [DW-1:0] d;
    rreset();
    d = mk(2'b01, 1, 77);
    send(d, 7'b0000011);
    chk("R1 double error syndrome", diag_syndrome, 7'b0000011);
    chk("R1 double error cause", diag_cause, 1);
  endtask

  task automatic t_addr();
    rreset();
    send(mk(2'b01, NODES, 4), '0);
    chk("R2 abort on addr", abort_o, 1);
    chk("R2 cause", diag_cause, 2);
    chk("R2 syndrome zero", diag_syndrome, 0);
    send(mk(2'b10, 0, 1), 7'h01);
    chk("R5 later edc ignored cause", diag_cause, 2);
    chk("R5 later edc ignored syn", diag_syndrome, 0);
    send(mk(2'b01, 0, 1), '0);
    chk("R4 abort stays", abort_o, 1);
  endtask

  task automatic t_seq();
    rreset();
    send(mk(2'b10, 0, 1), '0);
    chk("R3 data before head", diag_cause, 3);
    rreset();
    send_fwd("R3 head", mk(2'b01, 3, 0));
    send(mk(2'b01, 3, 0), '0);
    chk("R3 head inside pkt", diag_cause, 3);
    rreset();
    send(mk(2'b11, 0, 0), '0);
    chk("R3 term before head", diag_cause, 3);
  endtask

  task automatic t_priority();
    rreset();
    send(mk(2'b10, 0, 6), 7'h40);
    chk("R5 edc over seq", diag_cause, 1);
    chk("R5 edc syndrome", diag_syndrome, 7'h40);
    rreset();
    send_fwd("R5 head", mk(2'b01, 0, 0));
    send(mk(2'b01, 60, 0), '0);
    chk("R5 addr over seq", diag_cause, 2);
  endtask

  task automatic t_ring_reset();
    rreset();
    send(mk(2'b10, 0, 1), '0);
    chk("R9 pre abort", abort_o, 1);
    rreset();
    idle();
    chk("R9 pending abort symbol dropped", tx_valid, 0);
    send_fwd("R9 head ok", mk(2'b01, 5, 0));
    chk("R9 no abort after head", abort_o, 0);
    rreset();
    send(mk(2'b10, 0, 2), '0);
    chk("R9 state back to wait head", diag_cause, 3);
  endtask

  initial begin
    int k = 0;
    for (int c = 3; k < DW; c++) if ($countones(c) >= 2) begin cols[k] = c[5:0]; k++; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_legal();
    t_edc();
    t_double();
    t_addr();
    t_seq();
    t_priority();
    t_ring_reset();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule